// File: doc/BRIEF.md
# PS/2 Device Identification Sequencer

This block sits on the host side of a shared PS/2 port. It works out whether the attached device is a keyboard or a mouse. When it finds a mouse, it sets that mouse up so movement packets start to flow.

Bytes come in from a separate frame receiver as a one-cycle valid strobe with a data byte. Command bytes go out to a separate byte transmitter through a level request and a busy line.

The block first waits for the device's power-on self-test byte. It then listens for an identity byte:
- A zero classifies the device as a mouse.
- Any other byte, or silence for a programmable window, classifies it as a keyboard.

For a mouse it sends the stream-mode command and then the enable-reporting command. Each command must be acknowledged. A command that fails is sent once more. A second failure raises an error flag and puts the block back to waiting for a new self-test byte.

Top module: `ps2_ident_seq`

## Requirements
- R1: While rst_ni is low and after its release, is_mouse_o, ready_o, error_o and tx_req_o are 0.
- R2: Before the self-test byte 0xAA has been received, every other received byte is ignored: no command is requested and no flag changes.
- R3: A 0x00 byte as the first byte after 0xAA sets is_mouse_o and starts setup with command 0xEA. No command is ever requested while is_mouse_o is 0.
- R4: Any byte other than 0x00 as the first byte after 0xAA sets ready_o with is_mouse_o at 0, and no command is requested.
- R5: If no byte arrives, ready_o rises with is_mouse_o at 0 exactly ID_WAIT_CYC cycles after the clock edge that took in 0xAA.
- R6: Mouse setup sends 0xEA and then 0xF4. Each command must be answered with 0xFA, and ready_o rises with the 0xFA that answers 0xF4.
- R7: tx_req_o stays high with tx_data_o unchanged until tx_busy_i is seen high. The next command is requested only after tx_busy_i has fallen.
- R8: A reply other than 0xFA, or no reply within ACK_WAIT_CYC cycles after tx_busy_i falls, makes the block resend the same command once.
- R9: A second failure of the same command sets error_o, clears is_mouse_o and returns the block to waiting for 0xAA. The next 0xAA clears error_o.
- R10: A reply that arrives in the cycle the acknowledge window expires is judged as the reply, not as a timeout.
- R11: Once ready_o is high it stays high until reset. Later bytes, including 0xAA, request no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | One-cycle strobe: rx_data_i holds a received byte |
| rx_data_i | input | 8 | Received byte |
| tx_busy_i | input | 1 | Transmitter is sending a byte |
| tx_req_o | output | 1 | Request to send tx_data_o |
| tx_data_o | output | 8 | Command byte to send |
| is_mouse_o | output | 1 | Attached device classified as a mouse |
| ready_o | output | 1 | Identification (and mouse setup) complete |
| error_o | output | 1 | Mouse setup failed twice on one command |

## Verification
Two events can land on the same clock edge: a reply byte arriving and the acknowledge window running out. The bench provokes this by delaying the first acknowledge by exactly ACK_WAIT_CYC cycles after the end of transmission. In that case it expects exactly two commands (0xEA, 0xF4) and a ready mouse. A delay of one cycle more must instead give a resend of 0xEA before 0xF4, and a delay of one cycle less must behave like the collision case, so the judgement is pinned to a single edge.

// File: rtl/ps2id_pkg.sv
package ps2id_pkg;
  localparam logic [7:0] BYTE_SELFTEST  = 8'hAA;
  localparam logic [7:0] BYTE_MOUSE_ID  = 8'h00;
  localparam logic [7:0] BYTE_ACK       = 8'hFA;
  localparam logic [7:0] CMD_STREAM     = 8'hEA;
  localparam logic [7:0] CMD_REPORT_ON  = 8'hF4;

  typedef enum logic [2:0] {
    ST_WAIT_BAT, ST_WAIT_ID, ST_SEND, ST_XMIT, ST_ACK, ST_DONE
  } seq_st_e;

  typedef enum logic [1:0] {
    TX_IDLE, TX_REQ, TX_BUSY
  } tx_st_e;
endpackage

// File: rtl/ps2id_timer.sv
module ps2id_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  // fires in the last cycle of the window; consumer acts on the next edge
  assign expire_o = (cnt_q == W'(1));
endmodule

// File: rtl/ps2id_tx_port.sv
module ps2id_tx_port
  import ps2id_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] data_i,
  input  logic       tx_busy_i,
  output logic       tx_req_o,
  output logic [7:0] tx_data_o,
  output logic       done_o
);
  tx_st_e     st_q;
  logic [7:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TX_IDLE;
      data_q <= '0;
    end else begin
      unique case (st_q)
        TX_IDLE: if (start_i) begin
          data_q <= data_i;
          st_q   <= TX_REQ;
        end
        TX_REQ:  if (tx_busy_i)  st_q <= TX_BUSY;
        TX_BUSY: if (!tx_busy_i) st_q <= TX_IDLE;
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  assign tx_req_o  = (st_q == TX_REQ);
  assign tx_data_o = data_q;
  assign done_o    = (st_q == TX_BUSY) && !tx_busy_i;
endmodule

// File: rtl/ps2id_ctrl.sv
module ps2id_ctrl
  import ps2id_pkg::*;
#(
  parameter int ID_WAIT_CYC  = 2_000_000,
  parameter int ACK_WAIT_CYC = 2_500_000,
  parameter int TW           = 22
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          tx_done_i,
  input  logic          tmr_expire_i,
  output logic          start_o,
  output logic [7:0]    cmd_o,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          is_mouse_o,
  output logic          ready_o,
  output logic          error_o
);
  seq_st_e    st_q;
  logic [7:0] cmd_q;
  logic       retry_q, mouse_q, ready_q, error_q;
  logic       bat_seen;

  assign bat_seen = (st_q == ST_WAIT_BAT) && rx_valid_i && (rx_data_i == BYTE_SELFTEST);

  always_comb begin
    tmr_load_o = 1'b0;
    tmr_val_o  = TW'(ACK_WAIT_CYC);
    if (bat_seen) begin
      tmr_load_o = 1'b1;
      tmr_val_o  = TW'(ID_WAIT_CYC);
    end else if (st_q == ST_XMIT && tx_done_i) begin
      tmr_load_o = 1'b1;
    end
  end

  assign start_o    = (st_q == ST_SEND);
  assign cmd_o      = cmd_q;
  assign is_mouse_o = mouse_q;
  assign ready_o    = ready_q;
  assign error_o    = error_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_WAIT_BAT;
      cmd_q   <= '0;
      retry_q <= 1'b0;
      mouse_q <= 1'b0;
      ready_q <= 1'b0;
      error_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_WAIT_BAT: if (bat_seen) begin
          error_q <= 1'b0;
          st_q    <= ST_WAIT_ID;
        end
        ST_WAIT_ID: begin
          if (rx_valid_i && rx_data_i == BYTE_MOUSE_ID) begin
            mouse_q <= 1'b1;
            cmd_q   <= CMD_STREAM;
            retry_q <= 1'b0;
            st_q    <= ST_SEND;
          end else if (rx_valid_i || tmr_expire_i) begin
            ready_q <= 1'b1;
            st_q    <= ST_DONE;
          end
        end
        ST_SEND: st_q <= ST_XMIT;
        ST_XMIT: if (tx_done_i) st_q <= ST_ACK;
        ST_ACK: begin
          // a reply wins over an expiring window in the same cycle
          if (rx_valid_i && rx_data_i == BYTE_ACK) begin
            if (cmd_q == CMD_STREAM) begin
              cmd_q   <= CMD_REPORT_ON;
              retry_q <= 1'b0;
              st_q    <= ST_SEND;
            end else begin
              ready_q <= 1'b1;
              st_q    <= ST_DONE;
            end
          end else if (rx_valid_i || tmr_expire_i) begin
            if (!retry_q) begin
              retry_q <= 1'b1;
              st_q    <= ST_SEND;
            end else begin
              error_q <= 1'b1;
              mouse_q <= 1'b0;
              st_q    <= ST_WAIT_BAT;
            end
          end
        end
        ST_DONE: st_q <= ST_DONE;
        default: st_q <= ST_WAIT_BAT;
      endcase
    end
  end
endmodule

// File: rtl/ps2_ident_seq.sv
module ps2_ident_seq #(
  parameter int ID_WAIT_CYC  = 2_000_000,
  parameter int ACK_WAIT_CYC = 2_500_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       tx_busy_i,
  output logic       tx_req_o,
  output logic [7:0] tx_data_o,
  output logic       is_mouse_o,
  output logic       ready_o,
  output logic       error_o
);
  localparam int MAX_WAIT = (ID_WAIT_CYC > ACK_WAIT_CYC) ? ID_WAIT_CYC : ACK_WAIT_CYC;
  localparam int TW       = $clog2(MAX_WAIT + 1);

  logic          start, tx_done, tmr_load, tmr_expire;
  logic [7:0]    cmd;
  logic [TW-1:0] tmr_val;

  ps2id_ctrl #(
    .ID_WAIT_CYC (ID_WAIT_CYC),
    .ACK_WAIT_CYC(ACK_WAIT_CYC),
    .TW          (TW)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_valid_i  (rx_valid_i),
    .rx_data_i   (rx_data_i),
    .tx_done_i   (tx_done),
    .tmr_expire_i(tmr_expire),
    .start_o     (start),
    .cmd_o       (cmd),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .is_mouse_o  (is_mouse_o),
    .ready_o     (ready_o),
    .error_o     (error_o)
  );

  ps2id_tx_port u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .data_i   (cmd),
    .tx_busy_i(tx_busy_i),
    .tx_req_o (tx_req_o),
    .tx_data_o(tx_data_o),
    .done_o   (tx_done)
  );

  ps2id_timer #(.W(TW)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tmr_load),
    .val_i   (tmr_val),
    .expire_o(tmr_expire)
  );
endmodule

// File: rtl/ps2_ident_seq_chk.sv
module ps2_ident_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_valid_i,
  input logic [7:0] rx_data_i,
  input logic       tx_busy_i,
  input logic       tx_req_o,
  input logic [7:0] tx_data_o,
  input logic       is_mouse_o,
  input logic       ready_o,
  input logic       error_o
);
  p_req_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o && !tx_busy_i |=> tx_req_o && $stable(tx_data_o));

  p_cmd_only_mouse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> is_mouse_o);

  p_kbd_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !is_mouse_o |-> !tx_req_o);

  p_err_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !ready_o && !is_mouse_o);

  p_err_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o && rx_valid_i && rx_data_i == 8'hAA |=> !error_o);

  p_ready_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
endmodule

bind ps2_ident_seq ps2_ident_seq_chk u_chk (.*);

// File: tb/ps2_ident_seq_test.sv
module ps2_ident_seq_test;
  localparam int VID  = 60;
  localparam int VACK = 40;
  localparam int BLEN = 6;
  localparam logic [8:0] NONE = 9'h100;

  typedef struct packed {
    logic [8:0] id;
    logic [8:0] r0, r1, r2;
    logic       mouse, ready, err;
    logic [3:0] ncmd;
    logic [7:0] last;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{9'h000, 9'h0FA, 9'h0FA, NONE,   1'b1, 1'b1, 1'b0, 4'd2, 8'hF4},
    '{NONE,   NONE,   NONE,   NONE,   1'b0, 1'b1, 1'b0, 4'd0, 8'h00},
    '{9'h0AB, NONE,   NONE,   NONE,   1'b0, 1'b1, 1'b0, 4'd0, 8'h00},
    '{9'h000, 9'h0FE, 9'h0FA, 9'h0FA, 1'b1, 1'b1, 1'b0, 4'd3, 8'hF4},
    '{9'h000, 9'h0FA, NONE,   9'h0FA, 1'b1, 1'b1, 1'b0, 4'd3, 8'hF4},
    '{9'h000, 9'h0FA, 9'h0FC, NONE,   1'b0, 1'b0, 1'b1, 4'd3, 8'hF4},
    '{9'h000, NONE,   NONE,   NONE,   1'b0, 1'b0, 1'b1, 4'd2, 8'hEA}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tb_v = 1'b0;
  logic [7:0] tb_d = '0;
  logic md_v, busy;
  logic [7:0] md_d, cur;
  logic rx_valid;
  logic [7:0] rx_data;
  logic tx_req, is_mouse, ready, error_w;
  logic [7:0] tx_data;

  logic mdl_clr = 1'b1;
  logic [8:0] resp_b [3];
  int resp_d [3];
  logic [7:0] cmd_log [8];
  int n_cmd, resp_idx, dly, bcnt;
  logic prev_req, viol;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign rx_valid = tb_v | md_v;
  assign rx_data  = md_v ? md_d : tb_d;

  ps2_ident_seq #(.ID_WAIT_CYC(VID), .ACK_WAIT_CYC(VACK)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .tx_busy_i(busy), .tx_req_o(tx_req), .tx_data_o(tx_data),
    .is_mouse_o(is_mouse), .ready_o(ready), .error_o(error_w));

  // transmitter and device model
  always @(posedge clk) begin
    prev_req <= tx_req;
    if (mdl_clr) begin
      busy <= 0; bcnt <= 0; n_cmd <= 0; resp_idx <= 0; dly <= 0;
      md_v <= 0; md_d <= 0; cur <= 0; viol <= 0;
    end else begin
      md_v <= 0;
      if (tx_req && !prev_req && busy) viol <= 1;
      if (!busy) begin
        if (tx_req) begin busy <= 1; bcnt <= BLEN; cur <= tx_data; end
      end else if (bcnt == 1) begin
        busy <= 0;
        cmd_log[n_cmd[2:0]] <= cur;
        n_cmd <= n_cmd + 1;
        if (resp_idx < 3 && resp_b[resp_idx] != NONE) begin
          dly  <= resp_d[resp_idx];
          md_d <= resp_b[resp_idx][7:0];
        end
        resp_idx <= resp_idx + 1;
      end else bcnt <= bcnt - 1;
      if (dly != 0) begin
        if (dly == 1) md_v <= 1;
        dly <= dly - 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic set_resp(input logic [8:0] a, b, c, input int da, db, dc);
    resp_b[0] = a; resp_b[1] = b; resp_b[2] = c;
    resp_d[0] = da; resp_d[1] = db; resp_d[2] = dc;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0; mdl_clr = 1;
    repeat (3) @(negedge clk);
    rst_ni = 1; mdl_clr = 0;
  endtask

  task automatic clr_model();
    @(negedge clk); mdl_clr = 1;
    @(negedge clk); mdl_clr = 0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); tb_v = 1; tb_d = b;
    @(negedge clk); tb_v = 0;
  endtask

  function automatic string tag_of(input int i);
    case (i)
      0: return "R6";
      1: return "R5";
      2: return "R4";
      3: return "R8";
      4: return "R8 timeout";
      default: return "R9";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    set_resp(NONE, NONE, NONE, 1, 1, 1);
    // R1: reset state
    do_reset();
    chk("R1 mouse", is_mouse, 0);
    chk("R1 ready", ready, 0);
    chk("R1 error", error_w, 0);
    chk("R1 req", tx_req, 0);

    // R2: bytes before self-test ignored
    send(8'h00); send(8'hFA);
    repeat (VID + 20) @(negedge clk);
    chk("R2 ncmd", n_cmd, 0);
    chk("R2 ready", ready, 0);
    chk("R2 mouse", is_mouse, 0);

    // table
    for (int i = 0; i < 7; i++) begin
      set_resp(VEC[i].r0, VEC[i].r1, VEC[i].r2, 1, 1, 1);
      do_reset();
      send(8'hAA);
      if (VEC[i].id != NONE) send(VEC[i].id[7:0]);
      repeat (500) @(negedge clk);
      chk({tag_of(i), " mouse"}, is_mouse, VEC[i].mouse);
      chk({tag_of(i), " ready"}, ready, VEC[i].ready);
      chk({tag_of(i), " error"}, error_w, VEC[i].err);
      chk({tag_of(i), " ncmd"}, n_cmd, VEC[i].ncmd);
      if (VEC[i].ncmd != 0) chk({tag_of(i), " last cmd"}, cmd_log[VEC[i].ncmd - 1], VEC[i].last);
      chk("R7 no request while busy", viol, 0);
    end

    // R9: recovery from error on next self-test byte
    set_resp(9'h0FA, 9'h0FA, NONE, 1, 1, 1);
    clr_model();
    send(8'hAA);
    chk("R9 error cleared", error_w, 0);
    send(8'h00);
    repeat (300) @(negedge clk);
    chk("R9 ready after recovery", ready, 1);
    chk("R9 mouse after recovery", is_mouse, 1);

    // R11: later bytes ignored after ready
    send(8'hAA); send(8'h00); send(8'hFE);
    repeat (150) @(negedge clk);
    chk("R11 ncmd unchanged", n_cmd, 2);
    chk("R11 ready held", ready, 1);

    // R6: order of commands
    chk("R6 first cmd", cmd_log[0], 8'hEA);
    chk("R6 second cmd", cmd_log[1], 8'hF4);

    // R5: identity window boundary
    do_reset();
    send(8'hAA);
    repeat (VID - 2) @(negedge clk);
    chk("R5 not yet ready", ready, 0);
    repeat (2) @(negedge clk);
    chk("R5 ready at window end", ready, 1);
    chk("R5 keyboard", is_mouse, 0);

    // R10: reply in the expiry cycle, one before, and one after
    for (int k = -1; k <= 1; k++) begin
      set_resp(9'h0FA, 9'h0FA, 9'h0FA, VACK + k, 1, 1);
      do_reset();
      send(8'hAA); send(8'h00);
      repeat (400) @(negedge clk);
      chk("R10 ready", ready, 1);
      chk("R10 ncmd", n_cmd, (k == 1) ? 3 : 2);
      chk("R10 second cmd", cmd_log[1], (k == 1) ? 8'hEA : 8'hF4);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule